// File: doc/BRIEF.md
# Buffered Dual-Compare PWM Channel

This block is one pulse-width channel with its own up-counter and two compare values. Each compare value has two stages: a buffer stage that software fills through a simple write port, and an active stage that the matching logic uses. The counter runs from 1 up to the active B value and then starts over at 1. Each restart is a cycle boundary, and at that boundary both active values take their buffers in a single one-clock load window. An update-hold input can postpone that transfer, so that several channels can switch to new settings on the same cycle.

A match on the A value drives the output flip-flop to a selectable active level. A match on the B value drives it to the opposite level and also ends the period. A sticky flag records B matches, or both A and B matches, depending on a mode input. Software clears the flag with a one-clock clear pulse. The prescaler sits outside the block and reaches it only as a clock-enable (tick) input. During the load window, an A buffer value of 0 or 1 is honoured at once, so a duty-cycle change to the cycle start takes effect in the same cycle as the load.

Top module: `dcmp_pwm_chan`

## Requirements
- R1: The counter changes only on clocks with `tick_en` high. On such a clock it goes to 1 if its value is greater than or equal to the active B value, and otherwise it increments by 1.
- R2: The clock after each tick that returns the counter to 1 is a one-clock load window. At the end of that window, active A takes buffer A and active B takes buffer B. A write with `wr_sel`=0 fills buffer A and a write with `wr_sel`=1 fills buffer B, one clock after `wr_en`.
- R3: While `upd_hold` is high during the load window, both active values keep their previous contents.
- R4: A match happens only in the first clock that the counter holds a new value. An A match (counter equal to active A) sets `pwm_out` to `act_level` on the next clock. A B match (counter equal to active B) sets it to the inverse of `act_level`.
- R5: When an A match and a B match occur in the same clock, the output takes the B level.
- R6: In a load window that is not held, if buffer A is 0 or 1, an A match occurs regardless of active A.
- R7: With `flag_on_both`=0 only B matches set `flag`. With `flag_on_both`=1, A matches set it as well.
- R8: `flag` stays high until a clock with `flag_clr` high and no set event. A set event in the same clock as a clear leaves it high.
- R9: Reset clears the counter, both buffers, both active values, `pwm_out` and `flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaler enable; counter advances when high |
| wr_en | input | 1 | Buffer write strobe |
| wr_sel | input | 1 | Buffer select: 0 = A, 1 = B |
| wr_data | input | CW | Value written to the selected buffer |
| upd_hold | input | 1 | Blocks the buffer-to-active transfer |
| flag_on_both | input | 1 | Flag mode: 0 = B matches only, 1 = A and B matches |
| act_level | input | 1 | Output level driven by an A match |
| flag_clr | input | 1 | One-clock clear of the flag |
| pwm_out | output | 1 | Output flip-flop |
| flag | output | 1 | Sticky match flag |
| count | output | CW | Current counter value |

## Verification
The flag's set event and the software clear can land on the same clock. The bench holds `flag_clr` high through whole periods and also pulses it every few clocks, so that clears fall on B-match clocks and, with both-match mode on, on A-match clocks. It judges each clock against a bench-side model in which the set wins. The A and B matches also meet when both buffers carry the same value, and in that case the output must settle at the B level.

// File: rtl/dcmp_pkg.sv
package dcmp_pkg;

  localparam int NUM_CMP = 2;

  typedef enum logic {
    SEL_A = 1'b0,
    SEL_B = 1'b1
  } cmp_sel_e;

  // Output flip-flop next value: B match dominates, A match drives the level.
  function automatic logic out_next(input logic cur, input logic a_hit,
                                    input logic b_hit, input logic lvl);
    if (b_hit)      return ~lvl;
    else if (a_hit) return lvl;
    else            return cur;
  endfunction

  // Flag set event under the selected flag mode.
  function automatic logic flag_event(input logic a_hit, input logic b_hit,
                                      input logic both);
    return b_hit | (both & a_hit);
  endfunction

  // Sticky flag: set has priority over clear.
  function automatic logic flag_next(input logic cur, input logic set_evt,
                                     input logic clr);
    if (set_evt)  return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

endpackage

// File: rtl/dcmp_timebase.sv
module dcmp_timebase #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [CW-1:0] b_act,
  output logic [CW-1:0] cnt,
  output logic          fresh,
  output logic          load_p
);

  localparam logic [CW-1:0] ONE = CW'(1);

  function automatic logic at_end(input logic [CW-1:0] c, input logic [CW-1:0] b);
    return c >= b;
  endfunction

  function automatic logic [CW-1:0] cnt_next(input logic [CW-1:0] c, input logic [CW-1:0] b);
    return at_end(c, b) ? ONE : c + ONE;
  endfunction

  logic wrap_now;
  assign wrap_now = at_end(cnt, b_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      fresh  <= 1'b0;
      load_p <= 1'b0;
    end else begin
      fresh  <= tick_en;
      load_p <= tick_en & wrap_now;
      if (tick_en) cnt <= cnt_next(cnt, b_act);
    end
  end

  AST_WRAP_TO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && (cnt >= b_act) |=> cnt == ONE); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt)); // R1
  AST_LOAD_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    load_p |-> (cnt == ONE) && fresh); // R2

endmodule

// File: rtl/dcmp_regs.sv
module dcmp_regs
  import dcmp_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          load_p,
  input  logic          upd_hold,
  output logic [CW-1:0] a_act,
  output logic [CW-1:0] b_act,
  output logic [CW-1:0] a_buf,
  output logic          upd_p
);

  logic [NUM_CMP-1:0][CW-1:0] buf_w;
  logic [NUM_CMP-1:0][CW-1:0] act_w;

  assign upd_p = load_p & ~upd_hold;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_stage
    logic [CW-1:0] buf_q;
    logic [CW-1:0] act_q;
    logic          wr_hit;

    assign wr_hit = wr_en && (wr_sel == g[0]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        buf_q <= '0;
        act_q <= '0;
      end else begin
        if (upd_p)  act_q <= buf_q;
        if (wr_hit) buf_q <= wr_data;
      end
    end

    assign buf_w[g] = buf_q;
    assign act_w[g] = act_q;
  end

  assign a_act = act_w[SEL_A];
  assign b_act = act_w[SEL_B];
  assign a_buf = buf_w[SEL_A];

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    load_p && upd_hold |=> $stable(a_act) && $stable(b_act)); // R3
  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    upd_p |=> (a_act == $past(buf_w[SEL_A])) && (b_act == $past(buf_w[SEL_B]))); // R2
  AST_ACT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !load_p |=> $stable(a_act) && $stable(b_act)); // R2
  AST_BUF_B_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel |=> buf_w[SEL_B] == $past(wr_data)); // R2

endmodule

// File: rtl/dcmp_outstage.sv
module dcmp_outstage
  import dcmp_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fresh,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] a_act,
  input  logic [CW-1:0] b_act,
  input  logic [CW-1:0] a_buf,
  input  logic          upd_p,
  input  logic          act_level,
  input  logic          flag_on_both,
  input  logic          flag_clr,
  output logic          pwm_out,
  output logic          flag,
  output logic          a_hit,
  output logic          b_hit
);

  localparam logic [CW-1:0] ONE = CW'(1);

  // During an unheld load window a buffered A of 0 or 1 is used directly.
  function automatic logic a_bypass(input logic upd, input logic [CW-1:0] abuf);
    return upd && (abuf <= ONE);
  endfunction

  function automatic logic a_compare(input logic f, input logic byp,
                                     input logic [CW-1:0] c, input logic [CW-1:0] a);
    return f && (byp || (c == a));
  endfunction

  logic byp_now;
  logic set_evt;

  assign byp_now = a_bypass(upd_p, a_buf);
  assign a_hit   = a_compare(fresh, byp_now, cnt, a_act);
  assign b_hit   = fresh && (cnt == b_act);
  assign set_evt = flag_event(a_hit, b_hit, flag_on_both);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_out <= 1'b0;
      flag    <= 1'b0;
    end else begin
      pwm_out <= out_next(pwm_out, a_hit, b_hit, act_level);
      flag    <= flag_next(flag, set_evt, flag_clr);
    end
  end

  AST_A_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    a_hit && !b_hit |=> pwm_out == $past(act_level)); // R4
  AST_B_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    b_hit |=> pwm_out == !$past(act_level)); // R5
  AST_NO_HIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fresh |=> $stable(pwm_out)); // R4
  AST_BYPASS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    upd_p && (a_buf <= ONE) && !b_hit |=> pwm_out == $past(act_level)); // R6
  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(b_hit || (flag_on_both && a_hit))); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !flag_clr |=> flag); // R8
  AST_SET_OVER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    b_hit && flag_clr |=> flag); // R8

endmodule

// File: rtl/dcmp_pwm_chan.sv
module dcmp_pwm_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          upd_hold,
  input  logic          flag_on_both,
  input  logic          act_level,
  input  logic          flag_clr,
  output logic          pwm_out,
  output logic          flag,
  output logic [CW-1:0] count
);

  logic [CW-1:0] cnt_w;
  logic [CW-1:0] a_act_w;
  logic [CW-1:0] b_act_w;
  logic [CW-1:0] a_buf_w;
  logic          fresh_w;
  logic          load_w;
  logic          upd_w;
  logic          a_hit_w;
  logic          b_hit_w;

  dcmp_timebase #(.CW(CW)) u_timebase (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_en(tick_en),
    .b_act  (b_act_w),
    .cnt    (cnt_w),
    .fresh  (fresh_w),
    .load_p (load_w)
  );

  dcmp_regs #(.CW(CW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .load_p  (load_w),
    .upd_hold(upd_hold),
    .a_act   (a_act_w),
    .b_act   (b_act_w),
    .a_buf   (a_buf_w),
    .upd_p   (upd_w)
  );

  dcmp_outstage #(.CW(CW)) u_outstage (
    .clk         (clk),
    .rst_n       (rst_n),
    .fresh       (fresh_w),
    .cnt         (cnt_w),
    .a_act       (a_act_w),
    .b_act       (b_act_w),
    .a_buf       (a_buf_w),
    .upd_p       (upd_w),
    .act_level   (act_level),
    .flag_on_both(flag_on_both),
    .flag_clr    (flag_clr),
    .pwm_out     (pwm_out),
    .flag        (flag),
    .a_hit       (a_hit_w),
    .b_hit       (b_hit_w)
  );

  assign count = cnt_w;

  AST_B_HIT_ENDS_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    b_hit_w && tick_en |=> count == CW'(1)); // R1
  AST_LOAD_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    upd_w |-> (count == CW'(1)) && !a_hit_w || (count == CW'(1))); // R2

endmodule

// File: tb/dcmp_pwm_chan_bench.sv
module dcmp_pwm_chan_bench;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_sel = 1'b0;
  logic [CW-1:0] wr_data = '0;
  logic          upd_hold = 1'b0;
  logic          flag_on_both = 1'b0;
  logic          act_level = 1'b0;
  logic          flag_clr = 1'b0;
  logic          pwm_out;
  logic          flag;
  logic [CW-1:0] count;

  always #5 clk = ~clk;

  dcmp_pwm_chan #(.CW(CW)) u_dcmp_pwm_chan (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .upd_hold(upd_hold), .flag_on_both(flag_on_both),
    .act_level(act_level), .flag_clr(flag_clr), .pwm_out(pwm_out), .flag(flag),
    .count(count)
  );

  typedef struct packed {
    logic [CW-1:0] cnt;
    logic          out;
    logic          flg;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R9";
  bit    done = 1'b0;

  // Bench-side model state
  logic [CW-1:0] m_cnt = '0, m_a1 = '0, m_b1 = '0, m_a2 = '0, m_b2 = '0;
  logic          m_fresh = 1'b0, m_load = 1'b0, m_out = 1'b0, m_flg = 1'b0;

  // Advance the model by one clock from the rules in the brief.
  task automatic model_edge();
    logic          upd, ah, bh, endp;
    logic [CW-1:0] a2_old, b2_old;
    upd    = m_load && !upd_hold;
    ah     = m_fresh && ((upd && (m_a2 < 2)) || (m_cnt == m_a1));
    bh     = m_fresh && (m_cnt == m_b1);
    endp   = (m_cnt >= m_b1);
    a2_old = m_a2;
    b2_old = m_b2;
    if (bh)      m_out = !act_level;
    else if (ah) m_out = act_level;
    if (bh || (flag_on_both && ah)) m_flg = 1'b1;
    else if (flag_clr)              m_flg = 1'b0;
    m_load  = tick_en && endp;
    m_fresh = tick_en;
    if (tick_en) m_cnt = endp ? CW'(1) : m_cnt + CW'(1);
    if (upd) begin
      m_a1 = a2_old;
      m_b1 = b2_old;
    end
    if (wr_en) begin
      if (wr_sel) m_b2 = wr_data;
      else        m_a2 = wr_data;
    end
  endtask

  // Driver: one clock, expectation pushed to the scoreboard queue.
  task automatic tick();
    exp_t e;
    @(posedge clk);
    model_edge();
    e.cnt = m_cnt;
    e.out = m_out;
    e.flg = m_flg;
    exp_q.push_back(e);
    tag_q.push_back(cur_req);
    #2;
  endtask

  task automatic run(input int n);
    repeat (n) tick();
  endtask

  task automatic wr(input logic sel, input logic [CW-1:0] d);
    wr_en = 1'b1;
    wr_sel = sel;
    wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  // Monitor: pop and compare away from the active edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk += 3;
      if (count !== e.cnt) begin
        n_fail++;
        $display("FAIL %s count actual=%0d expected=%0d", t, count, e.cnt);
      end
      if (pwm_out !== e.out) begin
        n_fail++;
        $display("FAIL %s pwm_out actual=%0b expected=%0b", t, pwm_out, e.out);
      end
      if (flag !== e.flg) begin
        n_fail++;
        $display("FAIL %s flag actual=%0b expected=%0b", t, flag, e.flg);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(10 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R9: outputs after reset
    n_chk++;
    if (count !== '0 || pwm_out !== 1'b0 || flag !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 reset actual=%0d/%0b/%0b expected=0/0/0", count, pwm_out, flag);
    end
    rst_n = 1'b1;

    // R1: basic period with A=3, B=6
    cur_req = "R1";
    wr(1'b0, 16'd3);
    wr(1'b1, 16'd6);
    tick_en = 1'b1;
    run(30);
    // R1: prescaler gating
    for (int i = 0; i < 40; i++) begin
      tick_en = (i % 3 == 0);
      tick();
    end
    tick_en = 1'b1;

    // R2: buffer writes mid-cycle become active after the next boundary
    cur_req = "R2";
    run(2);
    wr(1'b1, 16'd9);
    wr(1'b0, 16'd4);
    run(30);

    // R3: hold blocks the transfer, then release
    cur_req = "R3";
    upd_hold = 1'b1;
    wr(1'b0, 16'd2);
    wr(1'b1, 16'd5);
    run(25);
    upd_hold = 1'b0;
    run(25);

    // R4: inverted active level
    cur_req = "R4";
    act_level = 1'b1;
    run(25);
    act_level = 1'b0;

    // R5: A and B on the same count
    cur_req = "R5";
    wr(1'b0, 16'd5);
    wr(1'b1, 16'd5);
    run(25);

    // R6: buffered A of 0 and of 1 during the load window
    cur_req = "R6";
    flag_on_both = 1'b1;
    wr(1'b0, 16'd0);
    wr(1'b1, 16'd6);
    run(20);
    wr(1'b0, 16'd1);
    run(20);
    upd_hold = 1'b1;
    wr(1'b0, 16'd0);
    run(15);
    upd_hold = 1'b0;

    // R7: flag modes with periodic clears
    cur_req = "R7";
    wr(1'b0, 16'd3);
    wr(1'b1, 16'd7);
    run(10);
    flag_on_both = 1'b0;
    for (int i = 0; i < 40; i++) begin
      flag_clr = (i % 5 == 0);
      tick();
    end
    flag_on_both = 1'b1;
    for (int i = 0; i < 40; i++) begin
      flag_clr = (i % 5 == 0);
      tick();
    end

    // R8: clear held high across set events
    cur_req = "R8";
    flag_clr = 1'b1;
    run(30);
    flag_clr = 1'b0;
    run(5);
    flag_clr = 1'b1;
    tick();
    flag_clr = 1'b0;
    run(10);

    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule